// File: doc/BRIEF.md
# Word/Byte General Register File

This block holds four 16-bit general-purpose registers. Every register can be handled as one full word or as two separate 8-bit registers, an upper byte (bits 15:8) and a lower byte (bits 7:0). A single write port and two independent read ports serve a datapath. Each port has a size select and a 3-bit register code. Together they pick a whole word or one byte half.

A byte write merges the new byte into the stored word and leaves the other half as it was. A byte read places the selected half in the low bits of the 16-bit read bus and zero-fills the upper bits. Reads are combinational from the stored state. A read in the same cycle as a write to the same register therefore sees the value from before the clock edge.

Register codes: for a word access, code bits 1:0 pick register 0..3 and bit 2 is ignored. For a byte access, bits 1:0 pick the register and bit 2 picks the half: 0 is the low byte and 1 is the high byte. Byte codes 0..3 are the low halves of registers 0..3, and codes 4..7 are their high halves.

Top module: `gp_regfile`

## Requirements
- R1: With we_i=1 and wsize_i=0 (word), all 16 bits of wdata_i are stored at the clock edge into the register selected by waddr_i[1:0]; waddr_i[2] has no effect.
- R2: With we_i=1 and wsize_i=1 (byte), wdata_i[7:0] is stored into register waddr_i[1:0], in the high half if waddr_i[2]=1 and in the low half if waddr_i[2]=0.
- R3: A byte write leaves the other half of the same register unchanged, and wdata_i[15:8] has no effect on it.
- R4: With size 0 (word), a read port returns the full register selected by address bits 1:0; address bit 2 has no effect.
- R5: With size 1 (byte), a read port returns the half selected by address bit 2 of register address[1:0] in bits 7:0, with bits 15:8 zero.
- R6: The two read ports operate independently and may address different registers and sizes in the same cycle.
- R7: A read of a register in the same cycle as a write to it returns the value held before that clock edge.
- R8: With we_i=0, no register changes, whatever the other write inputs are.
- R9: While rst_ni is low, all registers are cleared to zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write enable |
| wsize_i | input | 1 | Write size: 0 word, 1 byte |
| waddr_i | input | 3 | Write register code |
| wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| ra_size_i | input | 1 | Port A read size: 0 word, 1 byte |
| ra_addr_i | input | 3 | Port A register code |
| ra_data_o | output | 16 | Port A read data |
| rb_size_i | input | 1 | Port B read size: 0 word, 1 byte |
| rb_addr_i | input | 3 | Port B register code |
| rb_data_o | output | 16 | Port B read data |

## Verification
The hardest case to reach is a byte write landing on a word whose other half already holds a distinctive, non-zero value. Only then can a merge that clobbers or shifts the untouched half be seen. The stimulus first fills each register with a full word. It then writes single halves with garbage in wdata_i[15:8] and reads back the whole word and the opposite half. A same-cycle write and read on one register is driven through port B, before and after the edge, to expose any bypass path.

// File: rtl/gp_regs_pkg.sv
package gp_regs_pkg;
  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_BYTE = 1'b1
  } acc_size_e;
endpackage

// File: rtl/gp_wr_merge.sv
module gp_wr_merge #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              byte_i,
  input  logic              hi_i,
  output logic [WORD_W-1:0] new_o
);
  localparam int BYTE_W = WORD_W / 2;

  always_comb begin
    new_o = wdata_i;
    if (byte_i) begin
      new_o = old_i;
      if (hi_i) new_o[WORD_W-1:BYTE_W] = wdata_i[BYTE_W-1:0];
      else      new_o[BYTE_W-1:0]      = wdata_i[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/gp_rd_extract.sv
module gp_rd_extract #(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 16,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] regs_i,
  input  logic                            byte_i,
  input  logic [IDX_W:0]                  addr_i,
  output logic [WORD_W-1:0]               data_o
);
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] word_sel;

  assign word_sel = regs_i[addr_i[IDX_W-1:0]];

  always_comb begin
    data_o = word_sel;
    if (byte_i) begin
      data_o = '0;
      data_o[BYTE_W-1:0] = addr_i[IDX_W] ? word_sel[WORD_W-1:BYTE_W]
                                         : word_sel[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
  import gp_regs_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 16,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int CODE_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wsize_i,
  input  logic [CODE_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ra_size_i,
  input  logic [CODE_W-1:0] ra_addr_i,
  output logic [WORD_W-1:0] ra_data_o,
  input  logic              rb_size_i,
  input  logic [CODE_W-1:0] rb_addr_i,
  output logic [WORD_W-1:0] rb_data_o
);
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
  logic [WORD_W-1:0]               merged;
  logic [IDX_W-1:0]                widx;

  assign widx = waddr_i[IDX_W-1:0];

  gp_wr_merge #(.WORD_W(WORD_W)) u_merge (
    .old_i   (regs_q[widx]),
    .wdata_i (wdata_i),
    .byte_i  (acc_size_e'(wsize_i) == SZ_BYTE),
    .hi_i    (waddr_i[IDX_W]),
    .new_o   (merged)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && widx == IDX_W'(g))          regs_q[g] <= merged;
    end
  end

  gp_rd_extract #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_rd_a (
    .regs_i (regs_q),
    .byte_i (acc_size_e'(ra_size_i) == SZ_BYTE),
    .addr_i (ra_addr_i),
    .data_o (ra_data_o)
  );

  gp_rd_extract #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_rd_b (
    .regs_i (regs_q),
    .byte_i (acc_size_e'(rb_size_i) == SZ_BYTE),
    .addr_i (rb_addr_i),
    .data_o (rb_data_o)
  );
endmodule

// File: rtl/gp_regfile_chk.sv
module gp_regfile_chk #(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 16,
  parameter int IDX_W    = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            we_i,
  input logic                            wsize_i,
  input logic [IDX_W:0]                  waddr_i,
  input logic [WORD_W-1:0]               wdata_i,
  input logic                            ra_size_i,
  input logic [WORD_W-1:0]               ra_data_o,
  input logic                            rb_size_i,
  input logic [WORD_W-1:0]               rb_data_o,
  input logic [NUM_REGS-1:0][WORD_W-1:0] regs_q
);
  localparam int BYTE_W = WORD_W / 2;

  // R5
  byte_read_a_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_size_i |-> ra_data_o[WORD_W-1:BYTE_W] == '0);
  // R5
  byte_read_b_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_size_i |-> rb_data_o[WORD_W-1:BYTE_W] == '0);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_k
    // R1
    word_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !wsize_i && waddr_i[IDX_W-1:0] == IDX_W'(k))
      |=> regs_q[k] == $past(wdata_i));
    // R2 R3
    lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wsize_i && waddr_i == {1'b0, IDX_W'(k)})
      |=> (regs_q[k][BYTE_W-1:0] == $past(wdata_i[BYTE_W-1:0]))
          && $stable(regs_q[k][WORD_W-1:BYTE_W]));
    // R2 R3
    hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wsize_i && waddr_i == {1'b1, IDX_W'(k)})
      |=> (regs_q[k][WORD_W-1:BYTE_W] == $past(wdata_i[BYTE_W-1:0]))
          && $stable(regs_q[k][BYTE_W-1:0]));
    // R8
    no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && waddr_i[IDX_W-1:0] == IDX_W'(k)) |=> $stable(regs_q[k]));
  end
endmodule

bind gp_regfile gp_regfile_chk #(
  .NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .wsize_i   (wsize_i),
  .waddr_i   (waddr_i),
  .wdata_i   (wdata_i),
  .ra_size_i (ra_size_i),
  .ra_data_o (ra_data_o),
  .rb_size_i (rb_size_i),
  .rb_data_o (rb_data_o),
  .regs_q    (regs_q)
);

// File: tb/sim_gp_regfile.sv
module sim_gp_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, wsize_i = 1'b0;
  logic [2:0]  waddr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ra_size_i = 1'b0, rb_size_i = 1'b0;
  logic [2:0]  ra_addr_i = '0, rb_addr_i = '0;
  logic [15:0] ra_data_o, rb_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gp_regfile u0 (
    .clk_i, .rst_ni, .we_i, .wsize_i, .waddr_i, .wdata_i,
    .ra_size_i, .ra_addr_i, .ra_data_o,
    .rb_size_i, .rb_addr_i, .rb_data_o
  );

  // {req, we, wsize, waddr, wdata, rsize, raddr, expected on port A}
  localparam int NV = 13;
  localparam logic [44:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 3'd0, 16'h1234, 1'b0, 3'd0, 16'h1234}, // R1 word AX
    {4'd2, 1'b1, 1'b1, 3'd4, 16'h00AB, 1'b0, 3'd0, 16'hAB34}, // R2 high byte of reg0
    {4'd3, 1'b1, 1'b1, 3'd0, 16'hFFCD, 1'b0, 3'd0, 16'hABCD}, // R3 low byte, junk upper
    {4'd5, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h00AB}, // R5 high half read
    {4'd5, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd0, 16'h00CD}, // R5 low half read
    {4'd1, 1'b1, 1'b0, 3'd3, 16'h5A5A, 1'b0, 3'd3, 16'h5A5A}, // R1 word reg3
    {4'd3, 1'b1, 1'b1, 3'd3, 16'h0011, 1'b1, 3'd7, 16'h005A}, // R3 high kept
    {4'd2, 1'b1, 1'b1, 3'd7, 16'h0022, 1'b0, 3'd3, 16'h2211}, // R2 high byte reg3
    {4'd1, 1'b1, 1'b0, 3'd5, 16'h0F0F, 1'b0, 3'd1, 16'h0F0F}, // R1 code bit2 ignored
    {4'd2, 1'b1, 1'b1, 3'd6, 16'h0080, 1'b0, 3'd2, 16'h8000}, // R2 high byte reg2
    {4'd3, 1'b1, 1'b1, 3'd1, 16'h00EE, 1'b1, 3'd5, 16'h000F}, // R3 low write keeps high
    {4'd8, 1'b0, 1'b0, 3'd0, 16'hFFFF, 1'b0, 3'd0, 16'hABCD}, // R8 we low
    {4'd4, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd4, 16'hABCD}  // R4 read bit2 ignored
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R9 reset state
    ra_size_i = 1'b0; ra_addr_i = 3'd0; rb_size_i = 1'b0; rb_addr_i = 3'd3;
    #1 chk("R9 reset reg0", ra_data_o, 16'h0000);
    chk("R9 reset reg3", rb_data_o, 16'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {we_i, wsize_i, waddr_i, wdata_i} = VEC[i][40:20];
      @(posedge clk_i);
      #1;
      we_i = 1'b0;
      {ra_size_i, ra_addr_i} = VEC[i][19:16];
      #1 chk($sformatf("R%0d vector %0d", VEC[i][44:41], i), ra_data_o, VEC[i][15:0]);
    end

    // R6 both ports, different regs and sizes
    @(negedge clk_i);
    ra_size_i = 1'b0; ra_addr_i = 3'd3; rb_size_i = 1'b1; rb_addr_i = 3'd6;
    #1 chk("R6 port A word reg3", ra_data_o, 16'h2211);
    chk("R6 port B high byte reg2", rb_data_o, 16'h0080);

    // R7 same-cycle write and read returns old value
    @(negedge clk_i);
    we_i = 1'b1; wsize_i = 1'b0; waddr_i = 3'd0; wdata_i = 16'h7777;
    rb_size_i = 1'b0; rb_addr_i = 3'd0;
    #1 chk("R7 old value before edge", rb_data_o, 16'hABCD);
    @(posedge clk_i);
    #1 we_i = 1'b0;
    #1 chk("R7 new value after edge", rb_data_o, 16'h7777);

    // R9 asynchronous clear mid-cycle
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 chk("R9 async clear reg0", rb_data_o, 16'h0000);
    ra_size_i = 1'b0; ra_addr_i = 3'd3;
    #1 chk("R9 async clear reg3", ra_data_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule